// File: doc/BRIEF.md
# Unified RV32I Shift Unit

This block computes the result of the six RV32I shift instructions (SLL, SRL, SRA and their immediate forms SLLI, SRLI, SRAI). It takes the raw 32-bit instruction word and both source operands, decodes what it needs from the instruction word, and returns a 32-bit result in the same cycle, with a flag that is high only when the word is one of the six supported shifts.

All six instructions go through a single arithmetic right shifter. Its operand is widened by one fill bit: that bit copies the sign of the first operand for arithmetic right shifts and is zero otherwise. A left shift reverses the bit order of the operand on the way in and of the shifter output on the way out, so the right shifter performs it too. The unit is purely combinational and is meant to sit beside the other ALU paths of an execute stage, which picks its result when the valid flag is set.

Top module: `shift_unit`

## Requirements
- R1: `valid_o` is high exactly when the opcode (instruction bits [6:0]) is 7'b0010011 (immediate form) or 7'b0110011 (register form) and either funct3 (bits [14:12]) is 3'b001 with funct7 (bits [31:25]) equal to 7'b0000000, or funct3 is 3'b101 with funct7 equal to 7'b0000000 or 7'b0100000.
- R2: When `valid_o` is low, `result_o` is zero.
- R3: Left shifts (funct3 3'b001) give the first operand shifted left by the shift amount, with zeros entering at bit 0, whatever the sign of the operand.
- R4: Logical right shifts (funct3 3'b101, funct7 7'b0000000) give the first operand shifted right with zeros entering at bit 31.
- R5: Arithmetic right shifts (funct3 3'b101, funct7 7'b0100000) give the first operand shifted right with copies of its bit 31 entering at the top.
- R6: For the immediate form the shift amount is instruction bits [24:20]; the second operand has no effect on the result.
- R7: For the register form the shift amount is bits [4:0] of the second operand and bits [31:5] have no effect; a left shift of 0xE0000000 with a second operand of 0x1FFFFFE2 gives 0x80000000.
- R8: A shift amount of 0 returns the first operand unchanged for every valid shift, and an amount of 31 leaves only one bit of the operand (plus fill) in the result.
- R9: The result and flag depend only on the current inputs, with no clock and no internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word being executed |
| rs1_i | input | 32 | First source operand, the value that is shifted |
| rs2_i | input | 32 | Second source operand, supplies the amount in register form |
| result_o | output | 32 | Shift result, zero when the instruction is not a supported shift |
| valid_o | output | 1 | High when the instruction is one of the six shifts |

## Verification
The bench pushes second operands with bits above bit 4 set, where a shifter reading six or more amount bits would return zero or a wrongly shifted value instead of the short shift that is required. It drives negative operands into left and logical right shifts, where a leaking fill bit would put ones into the vacated positions, and into arithmetic shifts, where a missing fill would clear the top bits. Amounts of 0 and 31 expose off-by-one errors in the stage wiring and in the bit reversal, and random instruction words with wrong funct7 or unrelated opcodes catch a decoder that accepts too much and leaves a non-zero result on the output.

// File: rtl/shift_pkg.sv
package shift_pkg;

    localparam int XLEN    = 32;
    localparam int SHAMT_W = $clog2(XLEN);

    localparam logic [6:0] OPC_ALU_IMM = 7'b0010011;
    localparam logic [6:0] OPC_ALU_REG = 7'b0110011;
    localparam logic [2:0] F3_LEFT     = 3'b001;
    localparam logic [2:0] F3_RIGHT    = 3'b101;
    localparam logic [6:0] F7_PLAIN    = 7'b0000000;
    localparam logic [6:0] F7_SIGNED   = 7'b0100000;

    typedef struct packed {
        logic               valid;
        logic               left;
        logic               arith;
        logic [SHAMT_W-1:0] amount;
    } shift_ctl_t;

endpackage

// File: rtl/shift_decode.sv
module shift_decode
    import shift_pkg::*;
(
    input  logic [XLEN-1:0] insn_i,
    input  logic [XLEN-1:0] rs2_i,
    output shift_ctl_t      ctl_o
);

    logic [6:0] opcode;
    logic [2:0] funct3;
    logic [6:0] funct7;
    logic       is_imm;
    logic       is_reg;
    logic       f_left;
    logic       f_right;

    assign opcode = insn_i[6:0];
    assign funct3 = insn_i[14:12];
    assign funct7 = insn_i[31:25];

    assign is_imm  = (opcode == OPC_ALU_IMM);
    assign is_reg  = (opcode == OPC_ALU_REG);
    assign f_left  = (funct3 == F3_LEFT)  && (funct7 == F7_PLAIN);
    assign f_right = (funct3 == F3_RIGHT) &&
                     ((funct7 == F7_PLAIN) || (funct7 == F7_SIGNED));

    always_comb begin
        ctl_o.valid  = (is_imm || is_reg) && (f_left || f_right);
        ctl_o.left   = (funct3 == F3_LEFT);
        ctl_o.arith  = funct7[5];
        ctl_o.amount = is_imm ? insn_i[20 +: SHAMT_W] : rs2_i[SHAMT_W-1:0];
    end

endmodule

// File: rtl/bit_reverse.sv
module bit_reverse #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign dout[i] = din[WIDTH-1-i];
    end

endmodule

// File: rtl/shift_core.sv
module shift_core #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH:0]   din,
    input  logic [AMT_W-1:0] amount,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH:0] stage [AMT_W+1];

    assign stage[0] = din;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amount[k]
            ? {{STEP{stage[k][WIDTH]}}, stage[k][WIDTH:STEP]}
            : stage[k];
    end

    assign dout = stage[AMT_W][WIDTH-1:0];

endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
(
    input  logic [31:0] insn_i,
    input  logic [31:0] rs1_i,
    input  logic [31:0] rs2_i,
    output logic [31:0] result_o,
    output logic        valid_o
);

    shift_ctl_t      ctl;
    logic [XLEN-1:0] rs1_rev;
    logic [XLEN-1:0] pre_op;
    logic            fill_bit;
    logic [XLEN-1:0] core_out;
    logic [XLEN-1:0] core_rev;
    logic [XLEN-1:0] post_op;

    shift_decode u_decode (
        .insn_i (insn_i),
        .rs2_i  (rs2_i),
        .ctl_o  (ctl)
    );

    bit_reverse #(.WIDTH(XLEN)) u_rev_in (
        .din  (rs1_i),
        .dout (rs1_rev)
    );

    assign pre_op   = ctl.left ? rs1_rev : rs1_i;
    assign fill_bit = rs1_i[XLEN-1] & ctl.arith & ~ctl.left;

    shift_core #(.WIDTH(XLEN), .AMT_W(SHAMT_W)) u_core (
        .din    ({fill_bit, pre_op}),
        .amount (ctl.amount),
        .dout   (core_out)
    );

    bit_reverse #(.WIDTH(XLEN)) u_rev_out (
        .din  (core_out),
        .dout (core_rev)
    );

    assign post_op  = ctl.left ? core_rev : core_out;
    assign result_o = ctl.valid ? post_op : '0;
    assign valid_o  = ctl.valid;

endmodule

// File: rtl/shift_unit_checker.sv
module shift_unit_checker (
    input logic [31:0] insn_i,
    input logic [31:0] rs1_i,
    input logic [31:0] rs2_i,
    input logic [31:0] result_o,
    input logic        valid_o
);

    logic       imm_form;
    logic       is_left;
    logic       is_arith;
    logic [4:0] amt;

    always_comb begin
        imm_form = (insn_i[6:0] == 7'b0010011);
        is_left  = (insn_i[14:12] == 3'b001);
        is_arith = insn_i[30];
        amt      = imm_form ? insn_i[24:20] : rs2_i[4:0];
    end

    always_comb begin
        AST_IDLE_ZERO: assert (valid_o || result_o == 32'h0); // R2
        AST_ZERO_AMT_PASS: assert (!(valid_o && amt == 5'd0) || result_o == rs1_i); // R8
        AST_LEFT_LSB_CLEAR: assert (!(valid_o && is_left && amt != 5'd0) || !result_o[0]); // R3
        AST_LOGIC_MSB_CLEAR: assert (!(valid_o && !is_left && !is_arith && amt != 5'd0) || !result_o[31]); // R4
        AST_SIGN_KEPT: assert (!(valid_o && !is_left && is_arith) || result_o[31] == rs1_i[31]); // R5
    end

endmodule

bind shift_unit shift_unit_checker u_checker (
    .insn_i   (insn_i),
    .rs1_i    (rs1_i),
    .rs2_i    (rs2_i),
    .result_o (result_o),
    .valid_o  (valid_o)
);

// File: tb/tb_shift_unit.sv
module tb_shift_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn;
    logic [31:0] rs1;
    logic [31:0] rs2;
    logic [31:0] result;
    logic        valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    shift_unit dut (
        .insn_i   (insn),
        .rs1_i    (rs1),
        .rs2_i    (rs2),
        .result_o (result),
        .valid_o  (valid)
    );

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] f_rs2,
                                       input logic [2:0] f3, input logic [6:0] opc);
        return {f7, f_rs2, 5'd7, f3, 5'd3, opc};
    endfunction

    function automatic bit model_valid(input logic [31:0] w);
        bit opc_ok = (w[6:0] == 7'b0010011) || (w[6:0] == 7'b0110011);
        bit l_ok   = (w[14:12] == 3'b001) && (w[31:25] == 7'd0);
        bit r_ok   = (w[14:12] == 3'b101) && (w[31:25] == 7'd0 || w[31:25] == 7'b0100000);
        return opc_ok && (l_ok || r_ok);
    endfunction

    function automatic logic [31:0] model_result(input logic [31:0] w, input logic [31:0] a,
                                                 input logic [31:0] b);
        int sh;
        if (!model_valid(w)) return 32'h0;
        sh = (w[6:0] == 7'b0010011) ? int'(w[24:20]) : int'(b & 32'h1f);
        if (w[14:12] == 3'b001) return a << sh;
        if (w[30])              return $unsigned($signed(a) >>> sh);
        return a >> sh;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: insn=%h rs1=%h rs2=%h got=%h exp=%h", req, insn, rs1, rs2, got, exp);
        end
    endtask

    task automatic apply(input string req, input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] b);
        @(negedge clk);
        insn = w; rs1 = a; rs2 = b;
        #1;
        check({req, " R1 valid"}, {31'd0, valid}, {31'd0, model_valid(w)});
        check(req, result, model_result(w, a, b));
    endtask

    initial begin
        #200000;
        $display("FAIL watchdog: got=timeout exp=completion");
        errors++;
        checks++;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        insn = '0; rs1 = '0; rs2 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R9: idle inputs give a quiet output immediately
        check("R9 idle valid", {31'd0, valid}, 32'd0);
        check("R2 idle result", result, 32'd0);

        // R7: upper amount bits ignored, specific case
        apply("R7 sll high bits", mk(7'd0, 5'd0, 3'b001, 7'b0110011), 32'hE0000000, 32'h1FFFFFE2);
        check("R7 literal", result, 32'h80000000);
        apply("R7 srl high bits", mk(7'd0, 5'd0, 3'b101, 7'b0110011), 32'hF0F0F0F0, 32'hFFFFFFE4);
        apply("R7 sra high bits", mk(7'h20, 5'd0, 3'b101, 7'b0110011), 32'h80000001, 32'h00000020);

        // R3: left shift of a negative operand fills with zero
        apply("R3 sll neg", mk(7'd0, 5'd0, 3'b001, 7'b0110011), 32'hFFFFFFFF, 32'd4);
        apply("R3 slli", mk(7'd0, 5'd13, 3'b001, 7'b0010011), 32'h8000ABCD, 32'd0);
        // R4 / R5: logical vs arithmetic on a negative operand
        apply("R4 srl neg", mk(7'd0, 5'd0, 3'b101, 7'b0110011), 32'h80000000, 32'd31);
        apply("R4 srli", mk(7'd0, 5'd9, 3'b101, 7'b0010011), 32'hDEADBEEF, 32'd0);
        apply("R5 sra neg", mk(7'h20, 5'd0, 3'b101, 7'b0110011), 32'h80000000, 32'd31);
        apply("R5 srai", mk(7'h20, 5'd17, 3'b101, 7'b0010011), 32'hC0001234, 32'd0);
        apply("R5 srai pos", mk(7'h20, 5'd31, 3'b101, 7'b0010011), 32'h7FFFFFFF, 32'd0);

        // R6: immediate form ignores rs2
        apply("R6 slli rs2 junk", mk(7'd0, 5'd4, 3'b001, 7'b0010011), 32'h0000000F, 32'hFFFFFFFF);
        check("R6 literal", result, 32'h000000F0);

        // R8: amounts 0 and 31
        apply("R8 sll zero", mk(7'd0, 5'd0, 3'b001, 7'b0110011), 32'h12345678, 32'hFFFFFFE0);
        apply("R8 sra zero", mk(7'h20, 5'd0, 3'b101, 7'b0010011), 32'h87654321, 32'd5);
        apply("R8 sll 31", mk(7'd0, 5'd31, 3'b001, 7'b0010011), 32'h00000003, 32'd0);
        apply("R8 srl 31", mk(7'd0, 5'd0, 3'b101, 7'b0110011), 32'hFFFFFFFF, 32'h0000003F);

        // R1 / R2: near-miss encodings are rejected
        apply("R2 slli bad f7", mk(7'h20, 5'd3, 3'b001, 7'b0010011), 32'hFFFF0000, 32'd0);
        apply("R2 srl bad f7", mk(7'h01, 5'd0, 3'b101, 7'b0110011), 32'hFFFF0000, 32'd2);
        apply("R2 other f3", mk(7'd0, 5'd0, 3'b000, 7'b0110011), 32'h11111111, 32'd2);
        apply("R2 other opc", mk(7'd0, 5'd0, 3'b001, 7'b0000011), 32'h11111111, 32'd2);

        // R1..R8 sweep over random operands
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            int sel = $urandom_range(0, 7);
            case (sel)
                0: w = mk(7'd0, 5'($urandom), 3'b001, 7'b0110011);
                1: w = mk(7'd0, 5'($urandom), 3'b101, 7'b0110011);
                2: w = mk(7'h20, 5'($urandom), 3'b101, 7'b0110011);
                3: w = mk(7'd0, 5'($urandom), 3'b001, 7'b0010011);
                4: w = mk(7'd0, 5'($urandom), 3'b101, 7'b0010011);
                5: w = mk(7'h20, 5'($urandom), 3'b101, 7'b0010011);
                default: w = $urandom;
            endcase
            apply("R3R4R5 sweep", w, $urandom, $urandom);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule